// File: doc/BRIEF.md
# Capacity Allocation Control Unit

This unit holds the capacity allocation of a partitioned cache for every pairing of resource-control ID and access type. Each allocation is a set of capacity blocks, given as a bit mask, plus a limit on the capacity units the ID may occupy inside those blocks. Software sets an allocation in two steps. It first loads a staging block-mask register and a staging unit-limit register. It then writes the control inputs with an operation code, an ID and an access type. The unit checks the request and then does one of three things: it commits the staged values to its allocation table, copies a stored allocation back into the staging registers, or asks an external flush engine to evict what an ID holds.

The cache replacement logic reads the table through a separate combinational lookup port, with no cycle of delay. That port gives the allowed-block mask and the unit limit for the ID and access type of the request being served. Masks of different IDs may overlap. After reset every block belongs to ID 0 for every access type.

Top module: `capalloc_unit`

## Requirements
- R1: The staging mask register is read as MASK_W bits, which is NUM_BLKS rounded up to a multiple of 64 (64 with the defaults). Bits NUM_BLKS-1:0 take the written value, and every bit above them reads as 0.
- R2: After reset, busy is 0, status is 0, and both staging registers read 0. The lookup port gives all NUM_BLKS bits set and the all-ones unit limit for ID 0 under every access type. It gives a zero mask for every other ID.
- R3: A control write taken while busy is 0 makes busy read 1 from the next cycle on, and status reads 0 while busy is 1. Control, mask and unit writes presented while busy is 1 are ignored.
- R4: Operation code 1 (configure) with a non-empty staged mask stores the staged mask and unit limit for the given ID and access type. It ends busy one cycle after the write cycle with status 1, and from then on the lookup port returns the new values.
- R5: Operation code 1 with an all-zero staged mask ends with status 5 and leaves the table unchanged.
- R6: Operation code 2 (read back) loads the stored mask and unit limit of the given ID and access type into the staging registers and ends with status 1.
- R7: Operation code 3 (flush) holds flush_req high, with flush_rcid and flush_at set to the request, until flush_ack is seen. It then ends with status 1. It changes neither the table nor the staging registers.
- R8: Any operation code other than 1, 2 or 3 ends with status 2. A valid code with an ID of NUM_RCID or more, or an access type of NUM_AT or more, ends with status 3. The code check takes priority, and neither error changes the table.
- R9: Masks stored for different IDs may share blocks, and each is kept unchanged.
- R10: Allocations for different access types of one ID are independent. The access-type readback gives the access type of the last accepted control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr_en | input | 1 | Write strobe for the staging mask |
| mask_wr_data | input | MASK_W | Staging mask write data |
| mask_rd_data | output | MASK_W | Staging mask readback, zero above NUM_BLKS |
| units_wr_en | input | 1 | Write strobe for the staging unit limit |
| units_wr_data | input | UNIT_W | Staging unit-limit write data |
| units_rd_data | output | UNIT_W | Staging unit-limit readback |
| ctl_wr_en | input | 1 | Control write strobe, starts an operation |
| ctl_op | input | 5 | Operation code |
| ctl_rcid | input | 12 | Resource-control ID |
| ctl_at | input | 3 | Access type |
| ctl_at_rd | output | 3 | Access type of the last accepted request |
| busy | output | 1 | Operation in progress |
| status | output | 7 | Result of the last operation, 0 while busy |
| flush_req | output | 1 | Flush request to the flush engine |
| flush_rcid | output | 12 | ID to flush |
| flush_at | output | 3 | Access type to flush |
| flush_ack | input | 1 | Flush engine reports completion |
| lookup_rcid | input | 12 | ID of the request being served by the cache |
| lookup_at | input | 3 | Access type of the request being served |
| lookup_mask | output | NUM_BLKS | Blocks allowed for the lookup ID |
| lookup_units | output | UNIT_W | Unit limit for the lookup ID |

## Verification
The assertions assume the flush engine raises flush_ack only while flush_req is high. They also assume every strobe is a clean, known level at each clock edge. The bench drives all inputs at falling edges, and it pulses flush_ack for one cycle only after it has seen flush_req at a falling edge. It keeps flush_ack low at all other times. The writes made during a flush are deliberate, and they test that such writes have no effect.

// File: rtl/capalloc_pkg.sv
package capalloc_pkg;
  localparam int OP_W    = 5;
  localparam int STAT_W  = 7;
  localparam int RCID_FW = 12;
  localparam int AT_FW   = 3;

  localparam logic [OP_W-1:0] OP_CONFIG = 5'd1;
  localparam logic [OP_W-1:0] OP_READ   = 5'd2;
  localparam logic [OP_W-1:0] OP_FLUSH  = 5'd3;

  localparam logic [STAT_W-1:0] ST_NONE   = 7'd0;
  localparam logic [STAT_W-1:0] ST_OK     = 7'd1;
  localparam logic [STAT_W-1:0] ST_BADOP  = 7'd2;
  localparam logic [STAT_W-1:0] ST_BADID  = 7'd3;
  localparam logic [STAT_W-1:0] ST_NOBLK  = 7'd5;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_EXEC  = 2'd1,
    SEQ_FLUSH = 2'd2
  } seq_state_t;
endpackage

// File: rtl/capalloc_stage.sv
module capalloc_stage #(
  parameter int NUM_BLKS  = 16,
  parameter int UNIT_W    = 16,
  parameter bit HAS_UNITS = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_mask_we,
  input  logic [NUM_BLKS-1:0] sw_mask_d,
  input  logic                sw_units_we,
  input  logic [UNIT_W-1:0]   sw_units_d,
  input  logic                load_en,
  input  logic [NUM_BLKS-1:0] load_mask,
  input  logic [UNIT_W-1:0]   load_units,
  output logic [NUM_BLKS-1:0] mask_q,
  output logic [UNIT_W-1:0]   units_q
);
  logic [NUM_BLKS-1:0] mask_d;

  // a readback load wins over a software write in the same cycle
  always_comb begin
    mask_d = mask_q;
    if (load_en)         mask_d = load_mask;
    else if (sw_mask_we) mask_d = sw_mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  generate
    if (HAS_UNITS) begin : g_units
      logic [UNIT_W-1:0] units_d;
      always_comb begin
        units_d = units_q;
        if (load_en)          units_d = load_units;
        else if (sw_units_we) units_d = sw_units_d;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) units_q <= '0;
        else        units_q <= units_d;
      end
    end else begin : g_no_units
      logic unused_units;
      assign unused_units = sw_units_we ^ (^sw_units_d) ^ (^load_units);
      assign units_q = '0;
    end
  endgenerate
endmodule

// File: rtl/capalloc_table.sv
module capalloc_table #(
  parameter int NUM_BLKS = 16,
  parameter int UNIT_W   = 16,
  parameter int ENTRIES  = 16,
  parameter int ID0_ENTS = 2,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [NUM_BLKS-1:0] wr_mask,
  input  logic [UNIT_W-1:0]   wr_units,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [NUM_BLKS-1:0] rd_mask,
  output logic [UNIT_W-1:0]   rd_units,
  input  logic [IDX_W-1:0]    lk_idx,
  output logic [NUM_BLKS-1:0] lk_mask,
  output logic [UNIT_W-1:0]   lk_units
);
  logic [NUM_BLKS-1:0] mask_arr  [ENTRIES];
  logic [UNIT_W-1:0]   units_arr [ENTRIES];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      // entries of ID 0 come out of reset owning every block
      localparam logic [NUM_BLKS-1:0] RST_MASK  = (g < ID0_ENTS) ? '1 : '0;
      localparam logic [UNIT_W-1:0]   RST_UNITS = (g < ID0_ENTS) ? '1 : '0;
      logic                ent_we;
      logic [NUM_BLKS-1:0] m_q, m_d;
      logic [UNIT_W-1:0]   u_q, u_d;

      assign ent_we = wr_en && (wr_idx == IDX_W'(g));

      always_comb begin
        m_d = m_q;
        u_d = u_q;
        if (ent_we) begin
          m_d = wr_mask;
          u_d = wr_units;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          m_q <= RST_MASK;
          u_q <= RST_UNITS;
        end else begin
          m_q <= m_d;
          u_q <= u_d;
        end
      end

      assign mask_arr[g]  = m_q;
      assign units_arr[g] = u_q;
    end
  endgenerate

  always_comb begin
    rd_mask  = '0;
    rd_units = '0;
    lk_mask  = '0;
    lk_units = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_mask  = mask_arr[i];
        rd_units = units_arr[i];
      end
      if (lk_idx == IDX_W'(i)) begin
        lk_mask  = mask_arr[i];
        lk_units = units_arr[i];
      end
    end
  end
endmodule

// File: rtl/capalloc_seq.sv
module capalloc_seq
  import capalloc_pkg::*;
#(
  parameter int NUM_RCID = 8,
  parameter int AT_ENTS  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [OP_W-1:0]    ctl_op,
  input  logic [RCID_FW-1:0] ctl_rcid,
  input  logic [AT_FW-1:0]   ctl_at,
  input  logic               mask_empty,
  input  logic               flush_ack,
  output logic               busy,
  output logic [STAT_W-1:0]  status,
  output logic [RCID_FW-1:0] op_rcid,
  output logic [AT_FW-1:0]   op_at,
  output logic               tbl_we,
  output logic               stage_load,
  output logic               flush_req
);
  seq_state_t         state_q, state_d;
  logic [OP_W-1:0]    op_q, op_d;
  logic [RCID_FW-1:0] rcid_q, rcid_d;
  logic [AT_FW-1:0]   at_q, at_d;
  logic [STAT_W-1:0]  stat_q, stat_d;
  logic               op_known, id_ok;

  assign op_known = (op_q == OP_CONFIG) || (op_q == OP_READ) || (op_q == OP_FLUSH);
  assign id_ok    = (int'(rcid_q) < NUM_RCID) && (int'(at_q) < AT_ENTS);

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    rcid_d     = rcid_q;
    at_d       = at_q;
    stat_d     = stat_q;
    tbl_we     = 1'b0;
    stage_load = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (ctl_we) begin
          state_d = SEQ_EXEC;
          stat_d  = ST_NONE;
          op_d    = ctl_op;
          rcid_d  = ctl_rcid;
          // without per-type allocation the type field is held at zero
          at_d    = (AT_ENTS > 1) ? ctl_at : '0;
        end
      end
      SEQ_EXEC: begin
        state_d = SEQ_IDLE;
        if (!op_known) begin
          stat_d = ST_BADOP;
        end else if (!id_ok) begin
          stat_d = ST_BADID;
        end else if (op_q == OP_CONFIG) begin
          if (mask_empty) begin
            stat_d = ST_NOBLK;
          end else begin
            tbl_we = 1'b1;
            stat_d = ST_OK;
          end
        end else if (op_q == OP_READ) begin
          stage_load = 1'b1;
          stat_d     = ST_OK;
        end else begin
          state_d = SEQ_FLUSH;
        end
      end
      SEQ_FLUSH: begin
        if (flush_ack) begin
          state_d = SEQ_IDLE;
          stat_d  = ST_OK;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      op_q    <= '0;
      rcid_q  <= '0;
      at_q    <= '0;
      stat_q  <= ST_NONE;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      rcid_q  <= rcid_d;
      at_q    <= at_d;
      stat_q  <= stat_d;
    end
  end

  assign busy      = (state_q != SEQ_IDLE);
  assign flush_req = (state_q == SEQ_FLUSH);
  assign status    = stat_q;
  assign op_rcid   = rcid_q;
  assign op_at     = at_q;
endmodule

// File: rtl/capalloc_unit.sv
module capalloc_unit
  import capalloc_pkg::*;
#(
  parameter int NUM_BLKS  = 16,
  parameter int NUM_RCID  = 8,
  parameter int NUM_AT    = 2,
  parameter int UNIT_W    = 16,
  parameter bit HAS_UNITS = 1'b1,
  parameter bit PER_AT    = 1'b1,
  localparam int MASK_W   = ((NUM_BLKS + 63) / 64) * 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mask_wr_en,
  input  logic [MASK_W-1:0]   mask_wr_data,
  output logic [MASK_W-1:0]   mask_rd_data,
  input  logic                units_wr_en,
  input  logic [UNIT_W-1:0]   units_wr_data,
  output logic [UNIT_W-1:0]   units_rd_data,
  input  logic                ctl_wr_en,
  input  logic [4:0]          ctl_op,
  input  logic [11:0]         ctl_rcid,
  input  logic [2:0]          ctl_at,
  output logic [2:0]          ctl_at_rd,
  output logic                busy,
  output logic [6:0]          status,
  output logic                flush_req,
  output logic [11:0]         flush_rcid,
  output logic [2:0]          flush_at,
  input  logic                flush_ack,
  input  logic [11:0]         lookup_rcid,
  input  logic [2:0]          lookup_at,
  output logic [NUM_BLKS-1:0] lookup_mask,
  output logic [UNIT_W-1:0]   lookup_units
);
  localparam int AT_ENTS = PER_AT ? NUM_AT : 1;
  localparam int ENTRIES = NUM_RCID * AT_ENTS;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [NUM_BLKS-1:0] stg_mask, tbl_rd_mask, tbl_lk_mask;
  logic [UNIT_W-1:0]   stg_units, tbl_rd_units, tbl_lk_units;
  logic [11:0]         op_rcid;
  logic [2:0]          op_at, lk_at;
  logic                tbl_we, stage_load, lk_valid;
  logic [IDX_W-1:0]    op_idx, lk_idx;
  logic                sw_mask_we, sw_units_we;

  assign sw_mask_we  = mask_wr_en  && !busy;
  assign sw_units_we = units_wr_en && !busy;

  capalloc_seq #(
    .NUM_RCID (NUM_RCID),
    .AT_ENTS  (AT_ENTS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_wr_en),
    .ctl_op     (ctl_op),
    .ctl_rcid   (ctl_rcid),
    .ctl_at     (ctl_at),
    .mask_empty (~|stg_mask),
    .flush_ack  (flush_ack),
    .busy       (busy),
    .status     (status),
    .op_rcid    (op_rcid),
    .op_at      (op_at),
    .tbl_we     (tbl_we),
    .stage_load (stage_load),
    .flush_req  (flush_req)
  );

  capalloc_stage #(
    .NUM_BLKS  (NUM_BLKS),
    .UNIT_W    (UNIT_W),
    .HAS_UNITS (HAS_UNITS)
  ) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_mask_we  (sw_mask_we),
    .sw_mask_d   (mask_wr_data[NUM_BLKS-1:0]),
    .sw_units_we (sw_units_we),
    .sw_units_d  (units_wr_data),
    .load_en     (stage_load),
    .load_mask   (tbl_rd_mask),
    .load_units  (tbl_rd_units),
    .mask_q      (stg_mask),
    .units_q     (stg_units)
  );

  // entry index = ID * types + type; the sequencer range-checks before use
  assign op_idx   = IDX_W'(op_rcid) * IDX_W'(AT_ENTS) + IDX_W'(op_at);
  assign lk_at    = PER_AT ? lookup_at : 3'd0;
  assign lk_valid = (int'(lookup_rcid) < NUM_RCID) && (int'(lk_at) < AT_ENTS);
  assign lk_idx   = IDX_W'(lookup_rcid) * IDX_W'(AT_ENTS) + IDX_W'(lk_at);

  capalloc_table #(
    .NUM_BLKS (NUM_BLKS),
    .UNIT_W   (UNIT_W),
    .ENTRIES  (ENTRIES),
    .ID0_ENTS (AT_ENTS),
    .IDX_W    (IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_idx   (op_idx),
    .wr_mask  (stg_mask),
    .wr_units (stg_units),
    .rd_idx   (op_idx),
    .rd_mask  (tbl_rd_mask),
    .rd_units (tbl_rd_units),
    .lk_idx   (lk_idx),
    .lk_mask  (tbl_lk_mask),
    .lk_units (tbl_lk_units)
  );

  assign mask_rd_data  = MASK_W'(stg_mask);
  assign units_rd_data = stg_units;
  assign ctl_at_rd     = op_at;
  assign flush_rcid    = op_rcid;
  assign flush_at      = op_at;
  assign lookup_mask   = lk_valid ? tbl_lk_mask : '0;
  // with no unit limits an ID may fill its blocks completely
  assign lookup_units  = !HAS_UNITS ? '1 : (lk_valid ? tbl_lk_units : '0);
endmodule

// File: rtl/capalloc_unit_chk.sv
module capalloc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr_en,
  input logic        busy,
  input logic [6:0]  status,
  input logic        flush_req,
  input logic        flush_ack,
  input logic [11:0] flush_rcid,
  input logic [2:0]  flush_at
);
  assert_busy_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !busy) |=> busy);

  assert_status_clear_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status == 7'd0));

  assert_done_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status != 7'd0));

  assert_exec_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush_req) |=> (!busy || flush_req));

  assert_flush_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> busy);

  assert_flush_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> (flush_req && $stable(flush_rcid) && $stable(flush_at)));

  assert_status_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 7'd0) || (status == 7'd1) || (status == 7'd2) ||
    (status == 7'd3) || (status == 7'd5));
endmodule

bind capalloc_unit capalloc_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr_en  (ctl_wr_en),
  .busy       (busy),
  .status     (status),
  .flush_req  (flush_req),
  .flush_ack  (flush_ack),
  .flush_rcid (flush_rcid),
  .flush_at   (flush_at)
);

// File: tb/capalloc_unit_bench.sv
`timescale 1ns/1ps
module capalloc_unit_bench;
  localparam int NB = 16;
  localparam int UW = 16;
  localparam int MW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mask_wr_en, units_wr_en, ctl_wr_en, flush_ack;
  logic [MW-1:0] mask_wr_data, mask_rd_data;
  logic [UW-1:0] units_wr_data, units_rd_data, lookup_units;
  logic [4:0]    ctl_op;
  logic [11:0]   ctl_rcid, flush_rcid, lookup_rcid;
  logic [2:0]    ctl_at, ctl_at_rd, flush_at, lookup_at;
  logic          busy, flush_req;
  logic [6:0]    status;
  logic [NB-1:0] lookup_mask;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  capalloc_unit u_capalloc_unit (
    .clk(clk), .rst_n(rst_n),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .mask_rd_data(mask_rd_data),
    .units_wr_en(units_wr_en), .units_wr_data(units_wr_data), .units_rd_data(units_rd_data),
    .ctl_wr_en(ctl_wr_en), .ctl_op(ctl_op), .ctl_rcid(ctl_rcid), .ctl_at(ctl_at),
    .ctl_at_rd(ctl_at_rd), .busy(busy), .status(status),
    .flush_req(flush_req), .flush_rcid(flush_rcid), .flush_at(flush_at), .flush_ack(flush_ack),
    .lookup_rcid(lookup_rcid), .lookup_at(lookup_at),
    .lookup_mask(lookup_mask), .lookup_units(lookup_units)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_stage(input logic [MW-1:0] m, input logic [UW-1:0] u);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = m;
    units_wr_en = 1'b1; units_wr_data = u;
    @(negedge clk);
    mask_wr_en = 1'b0; units_wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [4:0] op, input logic [11:0] id, input logic [2:0] at);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_op = op; ctl_rcid = id; ctl_at = at;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    chk("R3 busy after write", 64'(busy), 64'd1);
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    chk("R3 busy cleared", 64'(busy), 64'd0);
  endtask

  task automatic look(input string tag, input logic [11:0] id, input logic [2:0] at,
                      input logic [NB-1:0] em, input logic [UW-1:0] eu);
    lookup_rcid = id; lookup_at = at;
    #1;
    chk(tag, 64'(lookup_mask), 64'(em));
    chk(tag, 64'(lookup_units), 64'(eu));
  endtask

  task automatic t_reset;
    chk("R2 busy", 64'(busy), 64'd0);
    chk("R2 status", 64'(status), 64'd0);
    chk("R2 mask stage", mask_rd_data, 64'd0);
    chk("R2 units stage", 64'(units_rd_data), 64'd0);
    look("R2 id0 at0", 12'd0, 3'd0, '1, '1);
    look("R2 id0 at1", 12'd0, 3'd1, '1, '1);
    look("R2 id5", 12'd5, 3'd0, '0, '0);
  endtask

  task automatic t_width;
    wr_stage('1, 16'd100);
    chk("R1 mask pad", mask_rd_data, 64'h0000_0000_0000_FFFF);
    wr_stage(64'h00F0, 16'd100);
    chk("R1 mask value", mask_rd_data, 64'h00F0);
  endtask

  task automatic t_config;
    do_op(5'd1, 12'd2, 3'd0);
    chk("R4 status", 64'(status), 64'd1);
    look("R4 lookup new", 12'd2, 3'd0, 16'h00F0, 16'd100);
    look("R10 other type", 12'd2, 3'd1, '0, '0);
  endtask

  task automatic t_overlap;
    wr_stage(64'h00FF, 16'd50);
    do_op(5'd1, 12'd3, 3'd0);
    chk("R9 status", 64'(status), 64'd1);
    look("R9 id3", 12'd3, 3'd0, 16'h00FF, 16'd50);
    look("R9 id2 kept", 12'd2, 3'd0, 16'h00F0, 16'd100);
  endtask

  task automatic t_per_type;
    wr_stage(64'h0F00, 16'd7);
    do_op(5'd1, 12'd2, 3'd1);
    chk("R10 at readback", 64'(ctl_at_rd), 64'd1);
    look("R10 at1", 12'd2, 3'd1, 16'h0F00, 16'd7);
    look("R10 at0 kept", 12'd2, 3'd0, 16'h00F0, 16'd100);
  endtask

  task automatic t_empty;
    wr_stage(64'h0, 16'd33);
    do_op(5'd1, 12'd2, 3'd0);
    chk("R5 status", 64'(status), 64'd5);
    look("R5 table kept", 12'd2, 3'd0, 16'h00F0, 16'd100);
  endtask

  task automatic t_read;
    wr_stage(64'h1234, 16'd999);
    do_op(5'd2, 12'd2, 3'd1);
    chk("R6 status", 64'(status), 64'd1);
    chk("R6 mask", mask_rd_data, 64'h0F00);
    chk("R6 units", 64'(units_rd_data), 64'd7);
  endtask

  task automatic t_flush;
    wr_stage(64'hAAAA, 16'd9);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_op = 5'd3; ctl_rcid = 12'd3; ctl_at = 3'd0;
    @(negedge clk);
    // writes while busy must be ignored (R3)
    ctl_op = 5'd1; ctl_rcid = 12'd4;
    mask_wr_en = 1'b1; mask_wr_data = 64'h5555;
    @(negedge clk);
    ctl_wr_en = 1'b0; mask_wr_en = 1'b0;
    @(negedge clk);
    chk("R7 req", 64'(flush_req), 64'd1);
    chk("R7 rcid", 64'(flush_rcid), 64'd3);
    chk("R7 at", 64'(flush_at), 64'd0);
    chk("R7 busy", 64'(busy), 64'd1);
    chk("R7 status during", 64'(status), 64'd0);
    flush_ack = 1'b1;
    @(negedge clk);
    flush_ack = 1'b0;
    chk("R7 done busy", 64'(busy), 64'd0);
    chk("R7 done req", 64'(flush_req), 64'd0);
    chk("R7 status", 64'(status), 64'd1);
    look("R7 table kept", 12'd3, 3'd0, 16'h00FF, 16'd50);
    chk("R3 mask write ignored", mask_rd_data, 64'hAAAA);
    chk("R7 units kept", 64'(units_rd_data), 64'd9);
    @(negedge clk);
    chk("R3 ctl write ignored", 64'(busy), 64'd0);
    look("R3 id4 untouched", 12'd4, 3'd0, '0, '0);
  endtask

  task automatic t_bad;
    do_op(5'd0, 12'd1, 3'd0);
    chk("R8 op0", 64'(status), 64'd2);
    do_op(5'd4, 12'd1, 3'd0);
    chk("R8 op4", 64'(status), 64'd2);
    do_op(5'd7, 12'd100, 3'd0);
    chk("R8 op before id", 64'(status), 64'd2);
    do_op(5'd1, 12'd8, 3'd0);
    chk("R8 rcid range", 64'(status), 64'd3);
    do_op(5'd1, 12'd1, 3'd2);
    chk("R8 at range", 64'(status), 64'd3);
    look("R8 table kept", 12'd1, 3'd0, '0, '0);
    look("R8 id0 kept", 12'd0, 3'd0, '1, '1);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mask_wr_en = 1'b0; units_wr_en = 1'b0; ctl_wr_en = 1'b0; flush_ack = 1'b0;
    mask_wr_data = '0; units_wr_data = '0;
    ctl_op = '0; ctl_rcid = '0; ctl_at = '0;
    lookup_rcid = '0; lookup_at = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_width;
    t_config;
    t_overlap;
    t_per_type;
    t_empty;
    t_read;
    t_flush;
    t_bad;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule